// File: doc/BRIEF.md
# Raster-to-Macroblock Band Buffer

This block takes a 4:2:0 raster video stream and hands it out as macroblocks. Luma and chroma arrive on two separate sample paths, each with its own valid strobe, framed by a horizontal sync pulse at the end of every line and a vertical sync pulse at the start of every frame. The writer stores each band of sixteen luma lines and eight chroma lines in one of two banks. When a band is complete, it hands that bank to the reader and carries on filling the other bank.

The reader runs on its own clock and raises a ready flag when a band is waiting. It then waits for a load request. On the request it streams the band left to right, one macroblock after another. Each macroblock is 16 rows of 16 luma samples in raster order, then the 8x8 Cb block, then the 8x8 Cr block, which is 384 samples. The two clock domains exchange only two toggle signals, band-full and band-free, and the sample storage is a pair of dual-port memories.

Top module: `raster_mb_buffer`

## Requirements
- R1: While either reset is asserted and right after it, `mb_ready`, `mb_valid` and `wr_ovf` are 0.
- R2: The 16th `hsync` pulse of a band makes `mb_ready` rise within 8 read-clock cycles. After only 15 lines, `mb_ready` stays 0.
- R3: While `mb_ready` is 1 and `ld_blk` is 0, `mb_valid` stays 0. The first sample appears two read-clock edges after the edge that samples `ld_blk` high.
- R4: A request yields LINE_W/16 macroblocks of 384 samples each, with `mb_valid` high on consecutive cycles. The luma sample at row r, column c of macroblock m is band line r, pixel m*16+c.
- R5: `mb_sob` is high on the first sample of every macroblock. `mb_eob` is high only on the last sample of the band.
- R6: `mb_ready` is 0 in the cycle `mb_eob` is shown. If a further band is already stored, `mb_ready` rises again afterwards.
- R7: Chroma samples on a line alternate Cb, Cr, Cb, Cr, starting with Cb, and are sent only on even luma lines. Line 2n fills chroma row n. Within a macroblock, Cb row r, column c is chroma row r, Cb sample m*8+c. The Cr block follows the same rule.
- R8: A second band may be written while the first waits unread. Bands are read out in the order they were written.
- R9: While both banks hold unread bands, input samples are dropped and `wr_ovf` is set. `wr_ovf` stays set until `vsync`, and the dropped samples leave stored bands unchanged.
- R10: `vsync` clears the line and column counts, so lines written before it do not count toward the next band.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side reset, active low |
| vsync | input | 1 | Frame start pulse |
| hsync | input | 1 | End-of-line pulse |
| y_valid | input | 1 | Luma sample strobe |
| y_data | input | DW | Luma sample |
| c_valid | input | 1 | Chroma sample strobe |
| c_data | input | DW | Chroma sample, Cb and Cr interleaved |
| wr_ovf | output | 1 | Sticky overflow flag, cleared by vsync |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side reset, active low |
| ld_blk | input | 1 | Load request for a ready band |
| mb_ready | output | 1 | A band is waiting or being sent |
| mb_valid | output | 1 | Output sample strobe |
| mb_data | output | DW | Output sample |
| mb_sob | output | 1 | First sample of a macroblock |
| mb_eob | output | 1 | Last sample of the band |

## Verification
- **Ready latency:** the band-full toggle passes three read-side flops, then the pending count, then the state register. `mb_ready` is therefore due within about five read cycles of the 16th `hsync`. The bench waits eight cycles before checking that it is high, and waits ten cycles before checking that it is still low after 15 lines.
- **Request to data:** the request moves the reader to its sending state on one edge. The memory read and output registers fill on the next edge. The bench checks that `mb_valid` is low one cycle after the request and that the first sample, with `mb_sob`, is present one cycle later.
- **Sample stream:** every sample after the first is checked on consecutive read cycles against values computed from the pixel pattern the bench wrote.
- **Overflow flag:** `wr_ovf` is checked on the write clock once the dropped line has been sent.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  localparam int LUMA_LINES   = 16;
  localparam int CHROMA_LINES = 8;
  localparam int MB_LUMA      = 256;
  localparam int MB_SAMPLES   = 384;

  typedef enum logic [1:0] {RD_IDLE, RD_WAIT, RD_SEND} rd_state_e;

  // word address of a luma sample in the two-bank luma store
  function automatic int luma_addr(int line_w, int bank, int row, int col);
    return (bank * LUMA_LINES + row) * line_w + col;
  endfunction

  // word address of a chroma sample; pos counts Cb/Cr pairs, comp 0=Cb 1=Cr
  function automatic int chroma_addr(int line_w, int bank, int row, int pos, int comp);
    return (bank * CHROMA_LINES + row) * line_w + 2 * pos + comp;
  endfunction
endpackage

// File: rtl/rmb_sync.sv
module rmb_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_in,
  output logic evt
);
  logic [2:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[1:0], tgl_in};
  end

  assign evt = sr[2] ^ sr[1];
endmodule

// File: rtl/rmb_dpram.sv
module rmb_dpram #(
  parameter int DW    = 8,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rmb_writer.sv
module rmb_writer
  import rmb_pkg::*;
#(
  parameter int LINE_W = 32,
  parameter int DW     = 8,
  localparam int YAW   = $clog2(2 * LUMA_LINES * LINE_W),
  localparam int CAW   = $clog2(2 * CHROMA_LINES * LINE_W),
  localparam int CW    = $clog2(LINE_W),
  localparam int LW    = $clog2(LUMA_LINES)
) (
  input  logic           wclk,
  input  logic           rst_n,
  input  logic           vsync,
  input  logic           hsync,
  input  logic           y_valid,
  input  logic [DW-1:0]  y_data,
  input  logic           c_valid,
  input  logic [DW-1:0]  c_data,
  input  logic           free_evt,
  output logic           y_we,
  output logic [YAW-1:0] y_waddr,
  output logic [DW-1:0]  y_wdata,
  output logic           c_we,
  output logic [CAW-1:0] c_waddr,
  output logic [DW-1:0]  c_wdata,
  output logic           full_tgl,
  output logic           ovf
);
  logic [1:0]    busy;
  logic          wbank, fbank;
  logic [LW-1:0] yline;
  logic [CW-1:0] ycol, ccol;
  logic          blocked;
  logic          band_done;

  assign blocked   = busy[wbank];
  assign band_done = hsync && !vsync && !blocked && (yline == LW'(LUMA_LINES - 1));

  assign y_we    = y_valid && !blocked && !vsync;
  assign c_we    = c_valid && !blocked && !vsync;
  assign y_wdata = y_data;
  assign c_wdata = c_data;
  assign y_waddr = YAW'(luma_addr(LINE_W, int'(wbank), int'(yline), int'(ycol)));
  assign c_waddr = CAW'(chroma_addr(LINE_W, int'(wbank), int'(yline >> 1),
                                    int'(ccol >> 1), int'(ccol[0])));

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= '0;
      wbank    <= 1'b0;
      fbank    <= 1'b0;
      yline    <= '0;
      ycol     <= '0;
      ccol     <= '0;
      full_tgl <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      if (free_evt) begin
        busy[fbank] <= 1'b0;
        fbank       <= ~fbank;
      end
      if (vsync) begin
        yline <= '0;
        ycol  <= '0;
        ccol  <= '0;
        ovf   <= 1'b0;
      end else begin
        if ((y_valid || c_valid) && blocked) ovf <= 1'b1;
        if (hsync) begin
          ycol <= '0;
          ccol <= '0;
          if (band_done) begin
            yline       <= '0;
            busy[wbank] <= 1'b1;
            wbank       <= ~wbank;
            full_tgl    <= ~full_tgl;
          end else if (!blocked) begin
            yline <= yline + LW'(1);
          end
        end else begin
          if (y_we) ycol <= ycol + CW'(1);
          if (c_we) ccol <= ccol + CW'(1);
        end
      end
    end
  end

  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!rst_n)
    ovf && !vsync |=> ovf); // R9
  AST_FREE_ONLY_BUSY: assert property (@(posedge wclk) disable iff (!rst_n)
    free_evt |-> busy[fbank]); // R8
  AST_DROP_FLAGS: assert property (@(posedge wclk) disable iff (!rst_n)
    y_valid && busy[wbank] && !vsync |=> ovf); // R9
endmodule

// File: rtl/rmb_reader.sv
module rmb_reader
  import rmb_pkg::*;
#(
  parameter int LINE_W = 32,
  parameter int DW     = 8,
  localparam int YAW   = $clog2(2 * LUMA_LINES * LINE_W),
  localparam int CAW   = $clog2(2 * CHROMA_LINES * LINE_W),
  localparam int NMB   = LINE_W / 16,
  localparam int MBW   = (NMB > 1) ? $clog2(NMB) : 1
) (
  input  logic           rclk,
  input  logic           rst_n,
  input  logic           full_evt,
  input  logic           ld_blk,
  output logic           free_tgl,
  output logic [YAW-1:0] y_raddr,
  output logic [CAW-1:0] c_raddr,
  input  logic [DW-1:0]  y_rdata,
  input  logic [DW-1:0]  c_rdata,
  output logic           mb_ready,
  output logic           mb_valid,
  output logic [DW-1:0]  mb_data,
  output logic           mb_sob,
  output logic           mb_eob
);
  rd_state_e      state;
  logic [1:0]     pending;
  logic           rbank;
  logic [MBW-1:0] mb;
  logic [8:0]     k;
  logic           issue, last_k, last_mb, band_end;
  logic           sel_q;

  assign issue    = (state == RD_SEND);
  assign last_k   = (int'(k) == MB_SAMPLES - 1);
  assign last_mb  = (int'(mb) == NMB - 1);
  assign band_end = issue && last_k && last_mb;
  assign mb_ready = (state != RD_IDLE);

  // luma: k[7:4] row, k[3:0] column; chroma: k[6] component, k[5:3] row, k[2:0] column
  assign y_raddr = YAW'(luma_addr(LINE_W, int'(rbank), int'(k[7:4]),
                                  int'(mb) * 16 + int'(k[3:0])));
  assign c_raddr = CAW'(chroma_addr(LINE_W, int'(rbank), int'(k[5:3]),
                                    int'(mb) * 8 + int'(k[2:0]), int'(k[6])));

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RD_IDLE;
      pending  <= '0;
      rbank    <= 1'b0;
      mb       <= '0;
      k        <= '0;
      free_tgl <= 1'b0;
    end else begin
      if (full_evt && !band_end)      pending <= pending + 2'd1;
      else if (!full_evt && band_end) pending <= pending - 2'd1;
      case (state)
        RD_IDLE: if (pending != 2'd0) state <= RD_WAIT;
        RD_WAIT: if (ld_blk) begin
          state <= RD_SEND;
          k     <= '0;
          mb    <= '0;
        end
        RD_SEND: begin
          if (last_k) begin
            k <= '0;
            if (last_mb) begin
              mb       <= '0;
              state    <= RD_IDLE;
              rbank    <= ~rbank;
              free_tgl <= ~free_tgl;
            end else begin
              mb <= mb + MBW'(1);
            end
          end else begin
            k <= k + 9'd1;
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      mb_valid <= 1'b0;
      mb_sob   <= 1'b0;
      mb_eob   <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      mb_valid <= issue;
      mb_sob   <= issue && (k == 9'd0);
      mb_eob   <= band_end;
      sel_q    <= k[8];
    end
  end

  assign mb_data = sel_q ? c_rdata : y_rdata;

  AST_PENDING_MAX: assert property (@(posedge rclk) disable iff (!rst_n)
    pending <= 2'd2); // R8
  AST_READY_DROP: assert property (@(posedge rclk) disable iff (!rst_n)
    mb_eob |-> !mb_ready); // R6
  AST_START_AFTER_REQ: assert property (@(posedge rclk) disable iff (!rst_n)
    $rose(mb_valid) |-> $past(ld_blk, 2)); // R3
  AST_EOB_ALONE: assert property (@(posedge rclk) disable iff (!rst_n)
    mb_eob |-> mb_valid && !mb_sob); // R5
endmodule

// File: rtl/raster_mb_buffer.sv
module raster_mb_buffer
  import rmb_pkg::*;
#(
  parameter int LINE_W = 32,
  parameter int DW     = 8,
  localparam int Y_DEPTH = 2 * LUMA_LINES * LINE_W,
  localparam int C_DEPTH = 2 * CHROMA_LINES * LINE_W,
  localparam int YAW     = $clog2(Y_DEPTH),
  localparam int CAW     = $clog2(C_DEPTH)
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          vsync,
  input  logic          hsync,
  input  logic          y_valid,
  input  logic [DW-1:0] y_data,
  input  logic          c_valid,
  input  logic [DW-1:0] c_data,
  output logic          wr_ovf,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          ld_blk,
  output logic          mb_ready,
  output logic          mb_valid,
  output logic [DW-1:0] mb_data,
  output logic          mb_sob,
  output logic          mb_eob
);
  logic           y_we, c_we;
  logic [YAW-1:0] y_waddr, y_raddr;
  logic [CAW-1:0] c_waddr, c_raddr;
  logic [DW-1:0]  y_wdata, c_wdata, y_rdata, c_rdata;
  logic           full_tgl, free_tgl, full_evt, free_evt;

  rmb_writer #(.LINE_W(LINE_W), .DW(DW)) u_writer (
    .wclk(wclk), .rst_n(wrst_n), .vsync(vsync), .hsync(hsync),
    .y_valid(y_valid), .y_data(y_data), .c_valid(c_valid), .c_data(c_data),
    .free_evt(free_evt),
    .y_we(y_we), .y_waddr(y_waddr), .y_wdata(y_wdata),
    .c_we(c_we), .c_waddr(c_waddr), .c_wdata(c_wdata),
    .full_tgl(full_tgl), .ovf(wr_ovf)
  );

  rmb_dpram #(.DW(DW), .DEPTH(Y_DEPTH)) u_luma_mem (
    .wclk(wclk), .we(y_we), .waddr(y_waddr), .wdata(y_wdata),
    .rclk(rclk), .raddr(y_raddr), .rdata(y_rdata)
  );

  rmb_dpram #(.DW(DW), .DEPTH(C_DEPTH)) u_chroma_mem (
    .wclk(wclk), .we(c_we), .waddr(c_waddr), .wdata(c_wdata),
    .rclk(rclk), .raddr(c_raddr), .rdata(c_rdata)
  );

  rmb_sync u_full_sync (.clk(rclk), .rst_n(rrst_n), .tgl_in(full_tgl), .evt(full_evt));
  rmb_sync u_free_sync (.clk(wclk), .rst_n(wrst_n), .tgl_in(free_tgl), .evt(free_evt));

  rmb_reader #(.LINE_W(LINE_W), .DW(DW)) u_reader (
    .rclk(rclk), .rst_n(rrst_n), .full_evt(full_evt), .ld_blk(ld_blk),
    .free_tgl(free_tgl), .y_raddr(y_raddr), .c_raddr(c_raddr),
    .y_rdata(y_rdata), .c_rdata(c_rdata),
    .mb_ready(mb_ready), .mb_valid(mb_valid), .mb_data(mb_data),
    .mb_sob(mb_sob), .mb_eob(mb_eob)
  );
endmodule

// File: tb/test_raster_mb_buffer.sv
`timescale 1ns/1ps
module test_raster_mb_buffer;
  localparam int LINE_W = 32;
  localparam int NMB    = LINE_W / 16;
  localparam int BAND_N = NMB * 384;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic vsync = 1'b0, hsync = 1'b0, y_valid = 1'b0, c_valid = 1'b0, ld_blk = 1'b0;
  logic [7:0] y_data = '0, c_data = '0;
  logic wr_ovf, mb_ready, mb_valid, mb_sob, mb_eob;
  logic [7:0] mb_data;
  int nchk = 0, nfail = 0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  raster_mb_buffer #(.LINE_W(LINE_W), .DW(8)) i_raster_mb_buffer (
    .wclk(wclk), .wrst_n(wrst_n), .vsync(vsync), .hsync(hsync),
    .y_valid(y_valid), .y_data(y_data), .c_valid(c_valid), .c_data(c_data),
    .wr_ovf(wr_ovf), .rclk(rclk), .rrst_n(rrst_n), .ld_blk(ld_blk),
    .mb_ready(mb_ready), .mb_valid(mb_valid), .mb_data(mb_data),
    .mb_sob(mb_sob), .mb_eob(mb_eob)
  );

  function automatic int lval(int b, int r, int c);
    return (b * 37 + r * 11 + c * 3) & 255;
  endfunction

  function automatic int cval(int b, int r, int pos, int comp);
    return (b * 53 + r * 19 + pos * 5 + comp * 97 + 7) & 255;
  endfunction

  function automatic int expect_sample(int b, int idx);
    int m = idx / 384;
    int k = idx % 384;
    if (k < 256) return lval(b, k / 16, m * 16 + k % 16);
    k = k - 256;
    return cval(b, (k % 64) / 8, m * 8 + k % 8, k / 64);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_line(input int b, input int line);
    for (int i = 0; i < LINE_W; i++) begin
      @(negedge wclk);
      y_valid = 1'b1;
      y_data  = 8'(lval(b, line, i));
      c_valid = (line % 2 == 0);
      c_data  = 8'(cval(b, line / 2, i / 2, i % 2));
    end
    @(negedge wclk);
    y_valid = 1'b0;
    c_valid = 1'b0;
    hsync   = 1'b1;
    @(negedge wclk);
    hsync   = 1'b0;
  endtask

  task automatic write_lines(input int b, input int first, input int last);
    for (int l = first; l <= last; l++) write_line(b, l);
  endtask

  task automatic vsync_pulse();
    @(negedge wclk); vsync = 1'b1;
    @(negedge wclk); vsync = 1'b0;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic read_band(input int b);
    @(negedge rclk);
    chk(mb_ready == 1'b1, "R2 ready before request", int'(mb_ready), 1);
    ld_blk = 1'b1;
    @(posedge rclk);
    @(negedge rclk);
    ld_blk = 1'b0;
    chk(mb_valid == 1'b0, "R3 one cycle after request", int'(mb_valid), 0);
    for (int idx = 0; idx < BAND_N; idx++) begin
      @(negedge rclk);
      chk(mb_valid == 1'b1, "R4 valid run", int'(mb_valid), 1);
      chk(int'(mb_data) == expect_sample(b, idx),
          (idx % 384 < 256) ? "R4 luma sample" : "R7 chroma sample",
          int'(mb_data), expect_sample(b, idx));
      chk(mb_sob == (idx % 384 == 0), "R5 sob", int'(mb_sob), int'(idx % 384 == 0));
      chk(mb_eob == (idx == BAND_N - 1), "R5 eob", int'(mb_eob), int'(idx == BAND_N - 1));
      if (idx == BAND_N - 1) chk(mb_ready == 1'b0, "R6 ready low at eob", int'(mb_ready), 0);
    end
    @(negedge rclk);
    chk(mb_valid == 1'b0, "R4 valid ends after band", int'(mb_valid), 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge rclk);
    nchk++;
    nfail++;
    $display("FAIL R4 watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    wait_r(3);
    chk(mb_ready == 1'b0, "R1 ready in reset", int'(mb_ready), 0);
    chk(mb_valid == 1'b0, "R1 valid in reset", int'(mb_valid), 0);
    chk(wr_ovf == 1'b0, "R1 ovf in reset", int'(wr_ovf), 0);
    wait_r(5);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    wait_r(3);
    chk(mb_ready == 1'b0 && mb_valid == 1'b0, "R1 idle after reset", int'(mb_ready), 0);

    vsync_pulse();
    write_lines(0, 0, 14);
    wait_r(10);
    chk(mb_ready == 1'b0, "R2 no ready after 15 lines", int'(mb_ready), 0);
    write_line(0, 15);
    wait_r(8);
    chk(mb_ready == 1'b1, "R2 ready after 16 lines", int'(mb_ready), 1);

    for (int i = 0; i < 40; i++) begin
      @(negedge rclk);
      chk(mb_valid == 1'b0, "R3 no data without request", int'(mb_valid), 0);
    end

    write_lines(1, 0, 15);
    @(negedge wclk);
    chk(wr_ovf == 1'b0, "R8 no overflow with two banks", int'(wr_ovf), 0);
    write_line(2, 0);
    @(negedge wclk);
    chk(wr_ovf == 1'b1, "R9 overflow when both banks held", int'(wr_ovf), 1);

    read_band(0);
    wait_r(8);
    chk(mb_ready == 1'b1, "R6 ready again for stored band", int'(mb_ready), 1);
    @(negedge wclk);
    chk(wr_ovf == 1'b1, "R9 overflow sticky", int'(wr_ovf), 1);
    vsync_pulse();
    @(negedge wclk);
    chk(wr_ovf == 1'b0, "R9 overflow cleared by vsync", int'(wr_ovf), 0);

    read_band(1);
    wait_r(8);
    chk(mb_ready == 1'b0, "R6 ready low with no band", int'(mb_ready), 0);

    vsync_pulse();
    write_lines(3, 0, 4);
    vsync_pulse();
    write_lines(4, 0, 14);
    wait_r(10);
    chk(mb_ready == 1'b0, "R10 vsync restarted line count", int'(mb_ready), 0);
    write_line(4, 15);
    wait_r(8);
    chk(mb_ready == 1'b1, "R10 band complete after restart", int'(mb_ready), 1);
    read_band(4);

    finish_run();
  end
endmodule